// File: doc/BRIEF.md
# Dual Programmable Clock Divider

This block derives two strobe outputs, a shift strobe and a video strobe, from one dot clock picked out of several clock sources. All of the logic runs in a single fast sampling clock domain. Each source is first captured as a level. The chosen level is then reduced to a one-cycle dot tick on each of its rising edges. Both outputs are taken from one shared 5-bit counter of dot ticks. Each output fires once every 2^n dot ticks, where n comes from its own 3-bit field in an 8-bit control word.

Software writes a new control word or source code at any time. The write goes into a pending copy. The active copy takes the new value only on the dot tick that wraps the counter back to zero. A ratio or source change therefore always starts on a clean divider boundary. The reserved ratio codes park the shift strobe low and the video strobe high. The counter keeps running in both parked states, so a later ratio change stays phase-aligned.

Top module: `dual_clk_div`

## Requirements
- R1: After reset both outputs are 0, the dot-tick counter is 0, the active control fields equal RST_CTRL and the active source code equals RST_SEL (defaults 0 and 0).
- R2: Each source input and the complement input pass through one register stage. The active 4-bit source code selects a level: 0..3 give inputs 0..3, 4 gives inverted input 3, and 8 gives input 3 AND NOT the complement input. Any other code gives input 0. A dot tick is a cycle in which the selected registered level is 1 and was 0 one cycle earlier.
- R3: Control bits [2:0] are the shift code n. For n in 0..5, sclk_o is 1 in the cycle after each dot tick on which the low n counter bits are all zero, which is one strobe per 2^n dot ticks. For codes 6 and 7, sclk_o stays 0.
- R4: Control bits [5:3] are the video code. They use the same encoding as the shift code and drive vclk_o. For codes 6 and 7, vclk_o stays 1.
- R5: The 5-bit counter advances by one on every dot tick and wraps from 31 to 0. It holds its value in all other cycles and keeps running whatever the codes are.
- R6: A write (ctrl_we or sel_we) updates only a pending copy, and a later write replaces an earlier one. The active control and source codes load the pending values on the dot tick that moves the counter from 31 to 0, and at no other time.
- R7: Control bits [7:6] have no effect on either output.
- R8: When the shift and video codes are equal and in 0..5, sclk_o and vclk_o are identical in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_clk | input | NUM_SRC | Raw clock source levels |
| src3_n | input | 1 | Complement of source 3 for the differential selection |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | CTRL_W | Control word: [2:0] shift code, [5:3] video code |
| sel_we | input | 1 | Write strobe for the source code |
| sel_wdata | input | SEL_W | Source selection code |
| sclk_o | output | 1 | Shift strobe, parked low on reserved codes |
| vclk_o | output | 1 | Video strobe, parked high on reserved codes |

## Verification
A corrupted counter shows up within one strobe period as a strobe in the wrong phase. It also breaks the spacing between strobes at the next wrap. A wrong active code, or one loaded outside the wrap, changes the strobe spacing within 2^n dot ticks of the bad update. A bad source mux shows up within one source period: the dot ticks, and so the strobes, follow the wrong input.

// File: rtl/dual_clk_div_pkg.sv
package dual_clk_div_pkg;

   typedef enum logic [3:0] {
      SRC_IN0     = 4'd0,
      SRC_IN1     = 4'd1,
      SRC_IN2     = 4'd2,
      SRC_IN3     = 4'd3,
      SRC_IN3_INV = 4'd4,
      SRC_DIFF3   = 4'd8
   } src_code_e;

   typedef enum logic {
      PARK_LOW  = 1'b0,
      PARK_HIGH = 1'b1
   } park_lvl_e;

   localparam int unsigned NUM_TAPS = 2;

endpackage

// File: rtl/dclk_src_sel.sv
module dclk_src_sel #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned SEL_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_clk,
   input  logic               src3_n,
   input  logic [SEL_W-1:0]   act_sel,
   output logic               dot_tick
);
   import dual_clk_div_pkg::*;

   localparam int unsigned CAP_W = NUM_SRC + 1;

   logic [CAP_W-1:0] cap_q;
   logic             lvl;
   logic             lvl_q;

   for (genvar i = 0; i < CAP_W; i++) begin : g_cap
      if (i < NUM_SRC) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_q[i] <= 1'b0;
            else        cap_q[i] <= src_clk[i];
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_q[i] <= 1'b0;
            else        cap_q[i] <= src3_n;
         end
      end
   end

   always_comb begin
      case (act_sel)
         SEL_W'(SRC_IN1):     lvl = cap_q[1];
         SEL_W'(SRC_IN2):     lvl = cap_q[2];
         SEL_W'(SRC_IN3):     lvl = cap_q[3];
         SEL_W'(SRC_IN3_INV): lvl = ~cap_q[3];
         SEL_W'(SRC_DIFF3):   lvl = cap_q[3] & ~cap_q[NUM_SRC];
         default:             lvl = cap_q[0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign dot_tick = lvl & ~lvl_q;

endmodule

// File: rtl/dclk_counter.sv
module dclk_counter #(
   parameter int unsigned CNT_W    = 5,
   parameter int unsigned FIELD_W  = 3,
   parameter int unsigned CTRL_W   = 8,
   parameter int unsigned SEL_W    = 4,
   parameter logic [CTRL_W-1:0] RST_CTRL = '0,
   parameter logic [SEL_W-1:0]  RST_SEL  = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   dot_tick,
   input  logic                   ctrl_we,
   input  logic [CTRL_W-1:0]      ctrl_wdata,
   input  logic                   sel_we,
   input  logic [SEL_W-1:0]       sel_wdata,
   output logic [CNT_W-1:0]       cnt,
   output logic [2*FIELD_W-1:0]   act_ctrl,
   output logic [SEL_W-1:0]       act_sel,
   output logic                   wrap
);
   localparam int unsigned FLD_TOT = 2 * FIELD_W;
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [FLD_TOT-1:0] pend_ctrl;
   logic [SEL_W-1:0]   pend_sel;

   assign wrap = dot_tick && (cnt == CNT_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (dot_tick) cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_ctrl <= RST_CTRL[FLD_TOT-1:0];
         pend_sel  <= RST_SEL;
      end else begin
         if (ctrl_we) pend_ctrl <= ctrl_wdata[FLD_TOT-1:0];
         if (sel_we)  pend_sel  <= sel_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_ctrl <= RST_CTRL[FLD_TOT-1:0];
         act_sel  <= RST_SEL;
      end else if (wrap) begin
         act_ctrl <= pend_ctrl;
         act_sel  <= pend_sel;
      end
   end

endmodule

// File: rtl/dclk_tap.sv
module dclk_tap #(
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned FIELD_W = 3,
   parameter logic        PARK    = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dot_tick,
   input  logic [CNT_W-1:0]   cnt,
   input  logic [FIELD_W-1:0] code,
   output logic               strobe
);
   logic [CNT_W-1:0] mask;
   logic             parked;
   logic             phase_hit;

   always_comb begin
      for (int i = 0; i < CNT_W; i++) begin
         mask[i] = (FIELD_W'(i) < code);
      end
   end

   assign parked    = (code > FIELD_W'(CNT_W));
   assign phase_hit = ((cnt & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      strobe <= 1'b0;
      else if (parked) strobe <= PARK;
      else             strobe <= dot_tick & phase_hit;
   end

endmodule

// File: rtl/dual_clk_div.sv
module dual_clk_div #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned SEL_W   = 4,
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned FIELD_W = 3,
   parameter int unsigned CTRL_W  = 8,
   parameter logic [CTRL_W-1:0] RST_CTRL = '0,
   parameter logic [SEL_W-1:0]  RST_SEL  = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_clk,
   input  logic               src3_n,
   input  logic               ctrl_we,
   input  logic [CTRL_W-1:0]  ctrl_wdata,
   input  logic               sel_we,
   input  logic [SEL_W-1:0]   sel_wdata,
   output logic               sclk_o,
   output logic               vclk_o
);
   import dual_clk_div_pkg::*;

   localparam int unsigned FLD_TOT = 2 * FIELD_W;
   localparam logic [NUM_TAPS-1:0] PARK_LVLS = {PARK_HIGH, PARK_LOW};

   if (NUM_SRC < 4) begin : g_bad_src
      $error("dual_clk_div: NUM_SRC must be at least 4");
   end
   if (SEL_W < 4) begin : g_bad_sel
      $error("dual_clk_div: SEL_W must be at least 4");
   end
   if (CTRL_W < FLD_TOT) begin : g_bad_ctrl
      $error("dual_clk_div: CTRL_W too narrow for two ratio fields");
   end
   if ((1 << FIELD_W) <= CNT_W) begin : g_bad_field
      $error("dual_clk_div: FIELD_W cannot encode all ratios");
   end

   logic                 dot_tick;
   logic [CNT_W-1:0]     cnt;
   logic [FLD_TOT-1:0]   act_ctrl;
   logic [SEL_W-1:0]     act_sel;
   logic                 wrap;
   logic [NUM_TAPS-1:0]  tap_out;

   dclk_src_sel #(
      .NUM_SRC (NUM_SRC),
      .SEL_W   (SEL_W)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_clk  (src_clk),
      .src3_n   (src3_n),
      .act_sel  (act_sel),
      .dot_tick (dot_tick)
   );

   dclk_counter #(
      .CNT_W    (CNT_W),
      .FIELD_W  (FIELD_W),
      .CTRL_W   (CTRL_W),
      .SEL_W    (SEL_W),
      .RST_CTRL (RST_CTRL),
      .RST_SEL  (RST_SEL)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .dot_tick   (dot_tick),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .sel_we     (sel_we),
      .sel_wdata  (sel_wdata),
      .cnt        (cnt),
      .act_ctrl   (act_ctrl),
      .act_sel    (act_sel),
      .wrap       (wrap)
   );

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      dclk_tap #(
         .CNT_W   (CNT_W),
         .FIELD_W (FIELD_W),
         .PARK    (PARK_LVLS[t])
      ) u_tap (
         .clk      (clk),
         .rst_n    (rst_n),
         .dot_tick (dot_tick),
         .cnt      (cnt),
         .code     (act_ctrl[t*FIELD_W +: FIELD_W]),
         .strobe   (tap_out[t])
      );
   end

   assign sclk_o = tap_out[0];
   assign vclk_o = tap_out[1];

endmodule

// File: rtl/dual_clk_div_chk.sv
module dual_clk_div_chk #(
   parameter int unsigned CNT_W   = 5,
   parameter int unsigned FIELD_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 dot_tick,
   input logic                 wrap,
   input logic [CNT_W-1:0]     cnt,
   input logic [2*FIELD_W-1:0] act_ctrl,
   input logic                 sclk_o,
   input logic                 vclk_o
);
   logic [FIELD_W-1:0] s_code;
   logic [FIELD_W-1:0] v_code;
   assign s_code = act_ctrl[FIELD_W-1:0];
   assign v_code = act_ctrl[2*FIELD_W-1:FIELD_W];

   a_r3_shift_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
      (s_code > FIELD_W'(CNT_W)) |=> !sclk_o);

   a_r4_video_parked_high: assert property (@(posedge clk) disable iff (!rst_n)
      (v_code > FIELD_W'(CNT_W)) |=> vclk_o);

   a_r3_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!dot_tick && s_code <= FIELD_W'(CNT_W)) |=> !sclk_o);

   a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      dot_tick |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !dot_tick |=> $stable(cnt));

   a_r6_load_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act_ctrl));

   a_r8_equal_codes_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (s_code == v_code && s_code <= FIELD_W'(CNT_W)) |=> (sclk_o == vclk_o));

endmodule

bind dual_clk_div dual_clk_div_chk #(
   .CNT_W   (CNT_W),
   .FIELD_W (FIELD_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dot_tick (dot_tick),
   .wrap     (wrap),
   .cnt      (cnt),
   .act_ctrl (act_ctrl),
   .sclk_o   (sclk_o),
   .vclk_o   (vclk_o)
);

// File: tb/dual_clk_div_test.sv
`timescale 1ns/1ps
module dual_clk_div_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] src_clk = '0;
   logic       src3_n = 1'b1;
   logic       ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = '0;
   logic       sel_we = 1'b0;
   logic [3:0] sel_wdata = '0;
   logic       sclk_o, vclk_o;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   dual_clk_div uut (
      .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .src3_n(src3_n),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .sel_we(sel_we),
      .sel_wdata(sel_wdata), .sclk_o(sclk_o), .vclk_o(vclk_o)
   );

   // ---------------- source generators ----------------
   int  hp [4] = '{0, 0, 0, 0};
   int  hc [4] = '{0, 0, 0, 0};
   bit  jitter = 0;
   bit  skew = 0;

   always @(negedge clk) begin
      for (int k = 0; k < 4; k++) begin
         if (hp[k] != 0) begin
            hc[k]++;
            if (hc[k] >= hp[k]) begin
               hc[k] = 0;
               src_clk[k] = ~src_clk[k];
               if (jitter) hp[k] = 1 + int'($urandom_range(3));
            end
         end
      end
      src3_n = skew ? (($urandom_range(1) == 0) ? ~src3_n : src3_n) : ~src_clk[3];
   end

   // ---------------- reference model ----------------
   function automatic bit sel_level(input logic [3:0] s, input logic [4:0] c);
      case (s)
         4'd1: return c[1];
         4'd2: return c[2];
         4'd3: return c[3];
         4'd4: return ~c[3];
         4'd8: return c[3] & ~c[4];
         default: return c[0];
      endcase
   endfunction

   function automatic bit strobe_of(input logic [2:0] code, input bit tick,
                                    input logic [4:0] c, input bit park);
      if (code >= 3'd6) return park;
      return tick && ((c % (5'd1 << code)) == 0);
   endfunction

   logic [4:0] m_cap, m_cnt;
   logic       m_prev, m_s, m_v;
   logic [5:0] m_act, m_pend;
   logic [3:0] m_asel, m_psel;

   always @(posedge clk) begin
      bit lv, tk;
      if (!rst_n) begin
         m_cap = '0; m_cnt = '0; m_prev = 0; m_s = 0; m_v = 0;
         m_act = '0; m_pend = '0; m_asel = '0; m_psel = '0;
      end else begin
         lv = sel_level(m_asel, m_cap);
         tk = lv & ~m_prev;
         m_s = strobe_of(m_act[2:0], tk, m_cnt, 1'b0);
         m_v = strobe_of(m_act[5:3], tk, m_cnt, 1'b1);
         if (tk && m_cnt == 5'd31) begin
            m_act  = m_pend;
            m_asel = m_psel;
         end
         if (tk) m_cnt = m_cnt + 5'd1;
         if (ctrl_we) m_pend = ctrl_wdata[5:0];
         if (sel_we)  m_psel = sel_wdata;
         m_prev = lv;
         m_cap  = {src3_n, src_clk};
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string t, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at cycle %0d", t, act, exp, cyc);
      end
   endtask

   bit cmp_en = 0;
   int s_cnt = 0, v_cnt = 0, diff_cnt = 0;

   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         chk({tag, " sclk"}, sclk_o, m_s);
         chk({tag, " vclk"}, vclk_o, m_v);
      end
      s_cnt += sclk_o;
      v_cnt += vclk_o;
      diff_cnt += (sclk_o != vclk_o);
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [7:0] d);
      @(negedge clk); ctrl_we = 1; ctrl_wdata = d;
      @(negedge clk); ctrl_we = 0;
   endtask

   task automatic wr_sel(input logic [3:0] d);
      @(negedge clk); sel_we = 1; sel_wdata = d;
      @(negedge clk); sel_we = 0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: got %0d expected below 150000 cycles", cyc);
         summary();
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      run(3);
      rst_n = 1;
      // R1: idle sources, outputs stay at reset values
      repeat (5) begin
         @(negedge clk);
         chk("R1 sclk reset", sclk_o, 0);
         chk("R1 vclk reset", vclk_o, 0);
      end
      cmp_en = 1;

      // R3/R4 rate: source 0 rises every 2 cycles
      tag = "R6";
      hp[0] = 1; hp[1] = 2; hp[2] = 3; hp[3] = 1;
      wr_ctrl({2'b00, 3'd1, 3'd3});
      run(200);
      s_cnt = 0; v_cnt = 0;
      tag = "R3";
      run(320);
      chk("R3 shift strobes div8 in 320 cycles", s_cnt, 20);
      chk("R4 video strobes div2 in 320 cycles", v_cnt, 80);

      // park codes
      tag = "R4";
      wr_ctrl({2'b00, 3'd7, 3'd6});
      run(200);
      s_cnt = 0; v_cnt = 0;
      run(100);
      chk("R3 shift parked low", s_cnt, 0);
      chk("R4 video parked high", v_cnt, 100);

      // equal codes
      tag = "R8";
      wr_ctrl({2'b00, 3'd2, 3'd2});
      run(200);
      diff_cnt = 0;
      run(300);
      chk("R8 equal codes identical", diff_cnt, 0);

      // every source code, fallback included
      tag = "R2";
      wr_ctrl({2'b00, 3'd0, 3'd1});
      for (int sc = 0; sc < 16; sc++) begin
         hp[0] = 1 + int'($urandom_range(3));
         hp[1] = 1 + int'($urandom_range(3));
         hp[2] = 1 + int'($urandom_range(3));
         hp[3] = 1 + int'($urandom_range(3));
         skew = (sc == 8);
         wr_sel(sc[3:0]);
         run(300);
      end
      skew = 0;

      // upper control bits ignored
      tag = "R7";
      wr_sel(4'd0);
      wr_ctrl(8'hC0 | {2'b00, 3'd2, 3'd4});
      run(300);
      wr_ctrl(8'h40 | {2'b00, 3'd5, 3'd0});
      run(300);

      // overwrite pending before wrap
      tag = "R6";
      wr_ctrl({2'b00, 3'd3, 3'd3});
      wr_ctrl({2'b00, 3'd0, 3'd5});
      run(300);

      // random mix
      tag = "R5";
      jitter = 1;
      for (int it = 0; it < 400; it++) begin
         case ($urandom_range(3))
            0: wr_ctrl(8'($urandom));
            1: wr_sel(4'($urandom_range(15)));
            default: ;
         endcase
         if ($urandom_range(9) == 0) skew = ~skew;
         run(int'($urandom_range(80)) + 10);
      end
      summary();
   end

endmodule